// File: doc/BRIEF.md
# DDS Serial Register Write Controller

This block loads the registers of a direct digital synthesis device through a three-wire serial port. A host presents a 7-bit register address, a read/write flag, a byte count from 1 to 6 and a data word of up to 48 bits, then pulses `start`. The controller sends one frame. The frame begins with an instruction byte that carries the flag and the address. The selected number of data bytes follows, most significant byte first. Once chip select has returned high, the controller pulses the update strobe, which commits the staged register contents.

After reset, and before it will accept any request, the block runs a power-up sequence. It pulses the device's master reset and then its serial-port reset. While that sequence or a frame is in progress, `busy` is high and a new `start` is ignored. A request whose byte count is out of range raises `err` for one cycle, and no frame is sent. For the two amplitude multiplier registers, the block forces the four unused upper bits of the 16-bit word to zero.

Top module: `dds_ser_writer`

## Requirements
- R1: Every byte is shifted out most significant bit first. `ser_dat` changes only while `ser_clk` is low and stays stable while `ser_clk` is high, so the device samples it on the rising edge of `ser_clk`.
- R2: The first byte of a frame is the instruction byte. Bit 7 of that byte equals `rd_req` (1 = read access, 0 = write access) and bits 6:0 equal `reg_addr`.
- R3: With byte count N, the instruction byte is followed by `wdata[8N-1:0]`, sent as N bytes from the most significant byte to the least significant byte.
- R4: A `start` accepted while idle with a byte count of 0 or greater than 6 raises `err` for exactly one cycle. In that case `busy` stays low and no frame is sent.
- R5: When the byte count is 2 and `reg_addr` equals `AMP_I_ADDR` (default 7'h08) or `AMP_Q_ADDR` (default 7'h09), bits 15:12 of the data word are sent as zero.
- R6: `dev_cs_n` is low from the first instruction bit through the last data bit. `ser_clk` is low whenever `dev_cs_n` is high, and it is left low after the final bit. `dev_cs_n` is high for at least one cycle before `dev_upd` rises.
- R7: `dev_upd` stays low while `dev_cs_n` is low. After each frame it is high for exactly `UPD_CYC` system clocks.
- R8: After reset, `dev_mrst` is high for `RST_CYC` clocks and then low. After that, `dev_iorst` is high for `RST_CYC` clocks. The two signals are never high together. During reset and during this sequence, `busy` is 1, `dev_cs_n` is 1, and `start` is ignored.
- R9: `busy` rises on the cycle after an accepted `start` and falls when `dev_upd` falls. A `start` that arrives while `busy` is high is ignored and raises no `err`.
- R10: One serial bit lasts `SCLK_DIV` system clocks (minimum 2). A frame of N data bytes keeps `dev_cs_n` low for exactly 8*(N+1)*`SCLK_DIV`+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, one cycle |
| rd_req | input | 1 | Read flag placed in instruction bit 7 |
| reg_addr | input | 7 | Target register address |
| byte_cnt | input | 3 | Number of data bytes, 1 to 6 |
| wdata | input | 48 | Data word; its low 8*N bits are sent |
| busy | output | 1 | Power-up sequence or frame in progress |
| err | output | 1 | One-cycle flag for a rejected byte count |
| dev_mrst | output | 1 | Master reset pulse to the device |
| dev_iorst | output | 1 | Serial-port reset pulse to the device |
| dev_cs_n | output | 1 | Active-low chip select |
| ser_clk | output | 1 | Serial clock |
| ser_dat | output | 1 | Serial data |
| dev_upd | output | 1 | Update strobe that commits staged registers |

## Verification
The bench decodes every frame from the serial pins and compares it with a scoreboard entry that it builds from the address, the flag and the count. A design that sent bytes least significant first, or that justified the data to the wrong end, would fail that comparison, and so would one that left the amplitude upper bits in place. The bench also sends requests during the power-up sequence and in the middle of a frame, and sends counts of 0 and 7. A design that honoured any of these would produce an unexpected frame or a stray `err`. The bench measures the length of chip select and of the update pulse, which exposes an extra or a missing bit period, or an update strobe that overlaps the frame.

// File: rtl/dds_wr_pkg.sv
package dds_wr_pkg;
  localparam int MAX_BYTES = 6;
  localparam int FRAME_W   = 8 * (MAX_BYTES + 1);

  typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP, F_UPD} fstate_t;
  typedef enum logic [2:0] {P_START, P_MR, P_GAP, P_IR, P_FIN} pstate_t;

  function automatic logic [7:0] instr_byte(input logic rd, input logic [6:0] addr);
    return {rd, addr};
  endfunction

  function automatic logic count_ok(input logic [2:0] n);
    return (n != 3'd0) && (int'(n) <= MAX_BYTES);
  endfunction

  // Total frame length in bits for n data bytes
  function automatic logic [5:0] frame_bits(input logic [2:0] n);
    return 6'(8 * (int'(n) + 1));
  endfunction

  // Clear the unused nibble of an amplitude multiplier word
  function automatic logic [47:0] amp_clean(input logic [6:0] addr, input logic [2:0] n,
                                            input logic [47:0] d, input logic [6:0] ai,
                                            input logic [6:0] aq);
    logic [47:0] r;
    r = d;
    if (n == 3'd2 && (addr == ai || addr == aq)) r[15:12] = 4'b0000;
    return r;
  endfunction

  // Instruction byte on top, data left-justified below it
  function automatic logic [FRAME_W-1:0] frame_vec(input logic [7:0] ins,
                                                   input logic [47:0] d, input logic [2:0] n);
    logic [47:0] just;
    just = d << (8 * (MAX_BYTES - int'(n)));
    return {ins, just};
  endfunction
endpackage

// File: rtl/dds_init_seq.sv
module dds_init_seq
  import dds_wr_pkg::*;
#(
  parameter int RST_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic mrst,
  output logic iorst,
  output logic ready
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] C_LAST = CW'(RST_CYC - 1);

  pstate_t       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= P_START; cnt <= '0; mrst <= 1'b0; iorst <= 1'b0; ready <= 1'b0;
    end else begin
      case (st)
        P_START: begin mrst <= 1'b1; cnt <= '0; st <= P_MR; end
        P_MR: if (cnt == C_LAST) begin mrst <= 1'b0; st <= P_GAP; end
              else cnt <= cnt + 1'b1;
        P_GAP: begin iorst <= 1'b1; cnt <= '0; st <= P_IR; end
        P_IR: if (cnt == C_LAST) begin iorst <= 1'b0; st <= P_FIN; end
              else cnt <= cnt + 1'b1;
        default: ready <= 1'b1;
      endcase
    end
  end

  AST_RESET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    iorst |-> !mrst); // R8
  AST_READY_AFTER_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mrst && !iorst)); // R8
endmodule

// File: rtl/dds_bit_shifter.sv
module dds_bit_shifter #(
  parameter int SCLK_DIV = 4,
  parameter int VEC_W    = 56,
  parameter int BIT_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VEC_W-1:0] load_vec,
  input  logic [BIT_W-1:0] load_bits,
  output logic             sclk,
  output logic             sdat,
  output logic             done
);
  localparam int LO_CYC = SCLK_DIV / 2;
  localparam int HI_CYC = SCLK_DIV - LO_CYC;
  localparam int PW     = $clog2(SCLK_DIV + 1);
  localparam logic [PW-1:0] LO_LAST = PW'(LO_CYC - 1);
  localparam logic [PW-1:0] HI_LAST = PW'(HI_CYC - 1);

  logic [VEC_W-1:0] sh;
  logic [BIT_W-1:0] left;
  logic [PW-1:0]    ph;
  logic             active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; left <= '0; ph <= '0; active <= 1'b0; sclk <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh <= load_vec; left <= load_bits; ph <= '0; active <= 1'b1; sclk <= 1'b0;
      end else if (active) begin
        if (!sclk) begin
          if (ph == LO_LAST) begin sclk <= 1'b1; ph <= '0; end
          else ph <= ph + 1'b1;
        end else if (ph == HI_LAST) begin
          sclk <= 1'b0; ph <= '0;
          if (left == BIT_W'(1)) begin active <= 1'b0; done <= 1'b1; end
          else begin sh <= {sh[VEC_W-2:0], 1'b0}; left <= left - 1'b1; end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  assign sdat = sh[VEC_W-1];

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat)); // R1
  AST_CLK_RESTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk); // R6
endmodule

// File: rtl/dds_frame_ctrl.sv
module dds_frame_ctrl
  import dds_wr_pkg::*;
#(
  parameter int UPD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic start,
  input  logic cnt_good,
  input  logic shift_done,
  output logic accept,
  output logic busy,
  output logic err,
  output logic cs_n,
  output logic upd
);
  localparam int UW = $clog2(UPD_CYC + 1);
  localparam logic [UW-1:0] U_LAST = UW'(UPD_CYC - 1);

  fstate_t       st;
  logic [UW-1:0] ucnt;
  logic          idle;
  logic          reject;

  assign idle   = (st == F_IDLE);
  assign accept = start && idle && ready && cnt_good;
  assign reject = start && idle && ready && !cnt_good;
  assign busy   = !ready || !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= F_IDLE; ucnt <= '0; err <= 1'b0; cs_n <= 1'b1; upd <= 1'b0;
    end else begin
      err <= reject;
      case (st)
        F_IDLE: if (accept) begin cs_n <= 1'b0; st <= F_SHIFT; end
        F_SHIFT: if (shift_done) begin cs_n <= 1'b1; st <= F_GAP; end
        F_GAP: begin upd <= 1'b1; ucnt <= '0; st <= F_UPD; end
        default: if (ucnt == U_LAST) begin upd <= 1'b0; st <= F_IDLE; end
                 else ucnt <= ucnt + 1'b1;
      endcase
    end
  end

  AST_CS_BEFORE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd) |-> $past(cs_n)); // R6
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !cs_n)); // R9
endmodule

// File: rtl/dds_ser_writer.sv
module dds_ser_writer
  import dds_wr_pkg::*;
#(
  parameter int         SCLK_DIV   = 4,
  parameter int         UPD_CYC    = 3,
  parameter int         RST_CYC    = 5,
  parameter logic [6:0] AMP_I_ADDR = 7'h08,
  parameter logic [6:0] AMP_Q_ADDR = 7'h09
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_req,
  input  logic [6:0]  reg_addr,
  input  logic [2:0]  byte_cnt,
  input  logic [47:0] wdata,
  output logic        busy,
  output logic        err,
  output logic        dev_mrst,
  output logic        dev_iorst,
  output logic        dev_cs_n,
  output logic        ser_clk,
  output logic        ser_dat,
  output logic        dev_upd
);
  localparam int BIT_W = $clog2(FRAME_W + 1);

  logic               ready;
  logic               accept;
  logic               shift_done;
  logic               cnt_good;
  logic [47:0]        data_clean;
  logic [FRAME_W-1:0] vec;
  logic [BIT_W-1:0]   nbits;

  assign cnt_good   = count_ok(byte_cnt);
  assign data_clean = amp_clean(reg_addr, byte_cnt, wdata, AMP_I_ADDR, AMP_Q_ADDR);
  assign vec        = frame_vec(instr_byte(rd_req, reg_addr), data_clean, byte_cnt);
  assign nbits      = BIT_W'(frame_bits(byte_cnt));

  dds_init_seq #(.RST_CYC(RST_CYC)) u_init (
    .clk(clk), .rst_n(rst_n), .mrst(dev_mrst), .iorst(dev_iorst), .ready(ready)
  );

  dds_frame_ctrl #(.UPD_CYC(UPD_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ready(ready), .start(start), .cnt_good(cnt_good),
    .shift_done(shift_done), .accept(accept), .busy(busy), .err(err),
    .cs_n(dev_cs_n), .upd(dev_upd)
  );

  dds_bit_shifter #(.SCLK_DIV(SCLK_DIV), .VEC_W(FRAME_W), .BIT_W(BIT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_vec(vec), .load_bits(nbits),
    .sclk(ser_clk), .sdat(ser_dat), .done(shift_done)
  );

  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cs_n |-> !ser_clk); // R6
  AST_UPD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dev_upd |-> dev_cs_n); // R7
  AST_ERR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R4
  AST_NO_FRAME_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_mrst || dev_iorst) |-> (dev_cs_n && busy)); // R8
endmodule

// File: tb/dds_ser_writer_bench.sv
module dds_ser_writer_bench;
  localparam int DIV = 4;
  localparam int UPD = 3;
  localparam int RST = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd_req = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [2:0]  byte_cnt = '0;
  logic [47:0] wdata = '0;
  logic busy, err, dev_mrst, dev_iorst, dev_cs_n, ser_clk, ser_dat, dev_upd;

  always #2.5 clk = ~clk;

  dds_ser_writer #(.SCLK_DIV(DIV), .UPD_CYC(UPD), .RST_CYC(RST)) u_dds_ser_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .reg_addr(reg_addr),
    .byte_cnt(byte_cnt), .wdata(wdata), .busy(busy), .err(err), .dev_mrst(dev_mrst),
    .dev_iorst(dev_iorst), .dev_cs_n(dev_cs_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .dev_upd(dev_upd)
  );

  typedef struct { int bits; logic [63:0] val; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0, pushed = 0, seen = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      summary();
    end
  end

  // Expected frame: R2 instruction {rd,addr}, R3 low 8N bits, R5 amplitude nibble cleared
  function automatic exp_t expect_frame(input logic rd, input logic [6:0] a, input int n, input logic [47:0] d);
    exp_t e;
    logic [63:0] payload;
    payload = {16'd0, d} & ((64'd1 << (8 * n)) - 64'd1);
    if (n == 2 && (a == 7'h08 || a == 7'h09)) payload[15:12] = 4'h0;
    e.bits = 8 * (n + 1);
    e.val  = ({56'd0, rd, a} << (8 * n)) | payload;
    return e;
  endfunction

  // Monitor: decodes serial pins, pops the scoreboard
  logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_upd = 1'b0;
  logic [63:0] cap = '0;
  int nbit = 0, cs_low = 0, upd_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!dev_cs_n) cs_low++;
      if (ser_clk && !prev_sclk && !dev_cs_n) begin cap = {cap[62:0], ser_dat}; nbit++; end
      if (dev_cs_n && !prev_cs) begin
        seen++;
        check(!ser_clk, "R6 clock low after frame", 64'(ser_clk), 64'd0);
        if (q.size() == 0) check(1'b0, "R8/R9 unexpected frame", 64'(nbit), 64'd0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(nbit == e.bits, "R3 bit count", 64'(nbit), 64'(e.bits));
          check((cap & ((64'd1 << e.bits) - 64'd1)) == e.val, "R1/R2/R3/R5 frame content",
                cap & ((64'd1 << e.bits) - 64'd1), e.val);
          check(cs_low == e.bits * DIV + 1, "R10 frame length", 64'(cs_low), 64'(e.bits * DIV + 1));
        end
        nbit = 0; cap = '0; cs_low = 0;
      end
      if (dev_upd) begin
        upd_len++;
        if (!prev_upd) check(prev_cs && dev_cs_n, "R6 cs high before update", 64'(prev_cs), 64'd1);
      end
      if (!dev_upd && prev_upd) begin
        check(upd_len == UPD, "R7 update width", 64'(upd_len), 64'(UPD));
        check(!busy, "R9 busy ends with update", 64'(busy), 64'd0);
        upd_len = 0;
      end
      prev_sclk = ser_clk; prev_cs = dev_cs_n; prev_upd = dev_upd;
    end
  end

  task automatic pulse(input logic rd, input logic [6:0] a, input logic [2:0] n, input logic [47:0] d);
    rd_req = rd; reg_addr = a; byte_cnt = n; wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send(input logic rd, input logic [6:0] a, input logic [2:0] n, input logic [47:0] d);
    while (busy) @(negedge clk);
    @(negedge clk);
    if (n != 0 && n <= 6) begin q.push_back(expect_frame(rd, a, int'(n), d)); pushed++; end
    pulse(rd, a, n, d);
    if (n != 0 && n <= 6) begin
      check(busy && !err, "R9 busy after accept", {62'd0, busy, err}, 64'h2);
    end else begin
      check(err && !busy, "R4 reject flags err", {62'd0, busy, err}, 64'h1);
      @(negedge clk);
      check(!err && !busy && dev_cs_n, "R4 err one cycle, no frame", {61'd0, err, busy, dev_cs_n}, 64'h1);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(dev_cs_n && !ser_clk && !dev_upd && !dev_mrst && busy, "R8 reset state",
          {59'd0, dev_cs_n, ser_clk, dev_upd, dev_mrst, busy}, 64'h11);
    rst_n = 1'b1;
    while (!dev_mrst) @(negedge clk);
    n = 0;
    while (dev_mrst) begin
      n++;
      if (n == 1) begin rd_req = 0; reg_addr = 7'h01; byte_cnt = 3'd2; wdata = 48'h1234; start = 1'b1; end
      if (n == 2) start = 1'b0;
      check(!dev_iorst && busy, "R8 master reset alone", {62'd0, dev_iorst, busy}, 64'h1);
      @(negedge clk);
    end
    check(n == RST, "R8 master reset width", 64'(n), 64'(RST));
    while (!dev_iorst) @(negedge clk);
    n = 0;
    while (dev_iorst) begin n++; @(negedge clk); end
    check(n == RST, "R8 io reset width", 64'(n), 64'(RST));
    repeat (2) @(negedge clk);
    check(!busy, "R8 ready after init", 64'(busy), 64'd0);

    send(1'b0, 7'h04, 3'd6, 48'h123456789ABC);
    send(1'b0, 7'h0C, 3'd2, 48'h0000_0000_BEEF);
    send(1'b0, 7'h08, 3'd2, 48'h0000_0000_FFFF);   // R5 I word
    send(1'b0, 7'h09, 3'd2, 48'hFFFF_FFFF_A5A5);   // R5 Q word
    send(1'b0, 7'h08, 3'd3, 48'h0000_00F1_F2F3);   // R5 not count 2
    send(1'b0, 7'h0A, 3'd3, 48'h0000_00C3_5A01);
    send(1'b0, 7'h07, 3'd4, 48'h0000_1044_0220);
    send(1'b1, 7'h05, 3'd1, 48'h0000_0000_0080);   // R2 read flag
    send(1'b0, 7'h02, 3'd0, 48'h1);                // R4
    send(1'b0, 7'h02, 3'd7, 48'h1);                // R4
    send(1'b0, 7'h06, 3'd5, 48'h00AA_BBCC_DDEE);
    repeat (5) @(negedge clk);
    pulse(1'b1, 7'h33, 3'd6, 48'hDEAD_BEEF_0000);  // R9 ignored
    check(busy && !err, "R9 start while busy ignored", {62'd0, busy, err}, 64'h2);
    pulse(1'b0, 7'h33, 3'd0, 48'h0);
    check(!err, "R9 bad count while busy no err", 64'(err), 64'd0);
    send(1'b0, 7'h03, 3'd6, 48'hFEDC_BA98_7654);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    check(q.size() == 0 && seen == pushed, "R9 frame count", 64'(seen), 64'(pushed));
    summary();
  end
endmodule